// File: doc/BRIEF.md
# Cascaded-Accumulator Fractional Offset Modulator

This block turns a programmed fraction `K / 2^ACC_W` into a stream of small signed integers whose long-run average equals that fraction. A fractional-N divider adds each value to its integer modulus, one value per divider output cycle, so that the average division ratio carries the fractional part. Three first-order accumulators are chained: each one accumulates the residue of the stage before it. Their carries are recombined either as a two-stage cascade or as a three-stage cascade, and the choice is made at run time.

A dither option feeds a toggling carry-in into the first accumulator on every other advance. This acts as one extra fraction bit fixed at one half. It raises the average by exactly half of one LSB, which breaks up short idle patterns. The block moves only on an advance strobe. A synchronous active-high reset clears every accumulator, every delay tap, the toggle and the output.

Top module: `mash_frac_mod`

## Requirements
- R1: While `rst` is high at a clock edge, all accumulators, the carry delay taps, the dither toggle and `offset_o` clear to zero. `offset_o` reads 0 after reset.
- R2: Each stage is an `ACC_W`-bit accumulator. Stage 1 adds `frac_i` plus the dither carry-in, and stage n>1 adds the new residue of stage n-1. A stage carries out (1) when its sum reaches `2^ACC_W`, and keeps the sum modulo `2^ACC_W`.
- R3: When `two_stage_i`=1 at an advance, the next `offset_o` is c1 + c2 - c2', where c2' is the stage-2 carry of the previous advance.
- R4: When `two_stage_i`=0 at an advance, the next `offset_o` is c1 + c2 - c2' + c3 - 2*c3' + c3'', where c3' and c3'' are the stage-3 carries one and two advances back.
- R5: `offset_o` is a 4-bit two's-complement value. It stays within -1..+2 after an advance in two-stage mode, and within -3..+4 after an advance in three-stage mode.
- R6: A clock edge with `step_i`=0 changes neither `offset_o` nor any internal state. The next advance continues the sequence as if no idle cycles had occurred.
- R7: With dither off and two-stage mode, the sum of `offset_o` over the first `2^ACC_W` advances after reset equals `frac_i`.
- R8: With `dither_i`=1, the stage-1 carry-in is the toggle bit, which is 0 at the first advance after reset and flips on each advance. In two-stage mode, the sum over the first `2^(ACC_W+1)` advances equals 2*`frac_i`+1.
- R9: Changing `two_stage_i` between advances takes effect on the next advance. It does not clear accumulators or taps, and the taps update in both modes.
- R10: An advance with `dither_i`=0 adds no carry-in and leaves the toggle bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance strobe, one per divider output cycle |
| frac_i | input | ACC_W | Fraction numerator K |
| two_stage_i | input | 1 | 1 selects the two-stage cascade, 0 the three-stage cascade |
| dither_i | input | 1 | 1 enables the half-LSB toggling carry-in |
| offset_o | output | 4 | Signed offset for the divider, registered |

## Verification
Every accumulator residue reaches the output through the carries. A wrong residue, tap or toggle value therefore shows as a wrong `offset_o` on the first advance where a carry differs. If it does not show there, it shifts the advance on which a later carry occurs, so the output sum over a full `2^ACC_W` window drifts away from `frac_i`. The bench runs a narrow accumulator. It compares every advance against an arithmetic reference and checks the window sums, so a divergence is caught on the advance where it first reaches a port. Idle cycles, mid-run mode changes and dither changes are mixed into the sequence, so state that leaks or resets wrongly shows as a per-step mismatch.

// File: rtl/mash_pkg.sv
package mash_pkg;

    localparam int MASH_OUT_W   = 4;
    localparam int MASH_NSTAGE  = 3;

    typedef logic signed [MASH_OUT_W-1:0] offset_t;

    typedef enum logic {
        CASCADE_THREE = 1'b0,
        CASCADE_TWO   = 1'b1
    } cascade_e;

    typedef struct packed {
        logic c3;
        logic c2;
        logic c1;
    } carry_vec_t;

    typedef struct packed {
        logic c3_dd;
        logic c3_d;
        logic c2_d;
    } tap_vec_t;

    // Recombine present carries with delayed carries into one signed offset.
    function automatic offset_t combine_carries(input carry_vec_t cur,
                                                input tap_vec_t   taps,
                                                input cascade_e   mode);
        int v;
        v = int'(cur.c1) + int'(cur.c2) - int'(taps.c2_d);
        if (mode == CASCADE_THREE) begin
            v = v + int'(cur.c3) - 2 * int'(taps.c3_d) + int'(taps.c3_dd);
        end
        return offset_t'(v);
    endfunction

endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
    parameter int ACC_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [ACC_W-1:0] in_val,
    input  logic             cin,
    output logic [ACC_W-1:0] res_o,
    output logic             carry_o
);
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, in_val} + SUM_W'(cin);
        res_o   = sum[ACC_W-1:0];
        carry_o = sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (adv) begin
            acc_q <= res_o;
        end
    end

    assert_acc_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(acc_q));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        carry_o |-> ({1'b0, res_o} < ({1'b0, in_val} + SUM_W'(cin))));

endmodule

// File: rtl/mash_lsb_toggle.sv
module mash_lsb_toggle (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic en,
    output logic cin_o
);
    logic tog_q;

    assign cin_o = tog_q & en;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= 1'b0;
        end else if (adv && en) begin
            tog_q <= ~tog_q;
        end
    end

    assert_toggle_flip_R8: assert property (@(posedge clk) disable iff (rst)
        (adv && en) |=> (tog_q != $past(tog_q)));

    assert_toggle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(adv && en) |=> $stable(tog_q));

    assert_no_cin_R10: assert property (@(posedge clk) disable iff (rst)
        !en |-> !cin_o);

endmodule

// File: rtl/mash_recombine.sv
module mash_recombine
    import mash_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    input  cascade_e            mode,
    input  carry_vec_t          carries,
    output offset_t             offset_o
);
    tap_vec_t taps_q;
    offset_t  out_q;
    offset_t  next_out;

    always_comb begin
        next_out = combine_carries(carries, taps_q, mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            taps_q <= '0;
            out_q  <= '0;
        end else if (adv) begin
            out_q        <= next_out;
            taps_q.c2_d  <= carries.c2;
            taps_q.c3_d  <= carries.c3;
            taps_q.c3_dd <= taps_q.c3_d;
        end
    end

    assign offset_o = out_q;

    assert_range_two_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == CASCADE_TWO) |=> (out_q >= -4'sd1 && out_q <= 4'sd2));

    assert_range_three_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == CASCADE_THREE) |=> (out_q >= -4'sd3 && out_q <= 4'sd4));

    assert_tap_shift_R4: assert property (@(posedge clk) disable iff (rst)
        adv |=> (taps_q.c3_dd == $past(taps_q.c3_d)));

endmodule

// File: rtl/mash_frac_mod.sv
module mash_frac_mod
    import mash_pkg::*;
#(
    parameter int ACC_W = 18
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          step_i,
    input  logic [ACC_W-1:0]              frac_i,
    input  logic                          two_stage_i,
    input  logic                          dither_i,
    output logic signed [MASH_OUT_W-1:0]  offset_o
);
    localparam int NST = MASH_NSTAGE;

    logic [ACC_W-1:0] stage_in  [NST];
    logic [ACC_W-1:0] stage_res [NST];
    logic [NST-1:0]   stage_cin;
    logic [NST-1:0]   stage_cry;
    logic             dith_cin;
    carry_vec_t       carries;
    cascade_e         mode;
    offset_t          rec_out;

    mash_lsb_toggle u_tog (
        .clk   (clk),
        .rst   (rst),
        .adv   (step_i),
        .en    (dither_i),
        .cin_o (dith_cin)
    );

    for (genvar g = 0; g < NST; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stage_in[g]  = frac_i;
            assign stage_cin[g] = dith_cin;
        end else begin : g_next
            assign stage_in[g]  = stage_res[g-1];
            assign stage_cin[g] = 1'b0;
        end

        mash_acc_stage #(.ACC_W(ACC_W)) u_acc (
            .clk     (clk),
            .rst     (rst),
            .adv     (step_i),
            .in_val  (stage_in[g]),
            .cin     (stage_cin[g]),
            .res_o   (stage_res[g]),
            .carry_o (stage_cry[g])
        );
    end

    assign carries = carry_vec_t'(stage_cry);
    assign mode    = two_stage_i ? CASCADE_TWO : CASCADE_THREE;

    mash_recombine u_rec (
        .clk      (clk),
        .rst      (rst),
        .adv      (step_i),
        .mode     (mode),
        .carries  (carries),
        .offset_o (rec_out)
    );

    assign offset_o = rec_out;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (offset_o == '0));

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(offset_o));

endmodule

// File: tb/mash_frac_mod_tb_top.sv
module mash_frac_mod_tb_top;
    localparam int W = 6;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         step_i = 1'b0;
    logic [W-1:0] frac_i = '0;
    logic         two_stage_i = 1'b1;
    logic         dither_i = 1'b0;
    logic signed [3:0] offset_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // reference state
    int m_a1, m_a2, m_a3, m_c2d, m_c3d, m_c3dd, m_tog, m_exp;

    always #5 clk = ~clk;

    mash_frac_mod #(.ACC_W(W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .step_i      (step_i),
        .frac_i      (frac_i),
        .two_stage_i (two_stage_i),
        .dither_i    (dither_i),
        .offset_o    (offset_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (K=%0d two=%0b dith=%0b)",
                     req, act, exp, frac_i, two_stage_i, dither_i);
        end
    endtask

    task automatic model_reset();
        m_a1 = 0; m_a2 = 0; m_a3 = 0;
        m_c2d = 0; m_c3d = 0; m_c3dd = 0; m_tog = 0; m_exp = 0;
    endtask

    // Arithmetic reference of one advance, from R2, R3, R4, R8, R10
    task automatic model_step();
        int s, c1, c2, c3, cin;
        cin = dither_i ? m_tog : 0;
        s = m_a1 + int'(frac_i) + cin; c1 = (s >= N) ? 1 : 0; m_a1 = s % N;
        s = m_a2 + m_a1;               c2 = (s >= N) ? 1 : 0; m_a2 = s % N;
        s = m_a3 + m_a2;               c3 = (s >= N) ? 1 : 0; m_a3 = s % N;
        m_exp = c1 + c2 - m_c2d;
        if (!two_stage_i) m_exp = m_exp + c3 - 2 * m_c3d + m_c3dd;
        m_c3dd = m_c3d; m_c3d = c3; m_c2d = c2;
        if (dither_i) m_tog = 1 - m_tog;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; step_i = 1'b0;
        @(negedge clk); rst = 1'b0;
        model_reset();
    endtask

    // one advance, output sampled on the following falling edge
    task automatic advance(input string req);
        step_i = 1'b1;
        model_step();
        @(negedge clk);
        step_i = 1'b0;
        check(req, int'(offset_o), m_exp);
    endtask

    task automatic range_check(input string req);
        int lo, hi;
        lo = two_stage_i ? -1 : -3;
        hi = two_stage_i ?  2 :  4;
        n_checks++;
        if (int'(offset_o) < lo || int'(offset_o) > hi) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected range %0d..%0d", req, offset_o, lo, hi);
        end
    endtask

    initial begin
        int sum;
        do_reset();
        check("R1 reset output", int'(offset_o), 0);

        // R3 / R7 sweep: every K, two-stage, no dither
        for (int k = 0; k < N; k++) begin
            two_stage_i = 1'b1; dither_i = 1'b0; frac_i = W'(k);
            do_reset();
            check("R1 output zero after reset", int'(offset_o), 0);
            sum = 0;
            for (int i = 0; i < N; i++) begin
                advance("R3 two-stage step");
                range_check("R5 two-stage range");
                sum += int'(offset_o);
            end
            check("R7 window sum equals K", sum, k);
        end

        // R4 sweep: every K, three-stage
        for (int k = 0; k < N; k++) begin
            two_stage_i = 1'b0; dither_i = 1'b0; frac_i = W'(k);
            do_reset();
            for (int i = 0; i < N; i++) begin
                advance("R4 three-stage step");
                range_check("R5 three-stage range");
            end
        end

        // R8 dither window sums in two-stage mode
        for (int j = 0; j < 5; j++) begin
            int kv;
            kv = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 21 : (j == 3) ? 40 : N - 1;
            two_stage_i = 1'b1; dither_i = 1'b1; frac_i = W'(kv);
            do_reset();
            sum = 0;
            for (int i = 0; i < 2 * N; i++) begin
                advance("R8 dither step");
                sum += int'(offset_o);
            end
            check("R8 dither window sum 2K+1", sum, 2 * kv + 1);
        end

        // R6 idle cycles, R9 mode switches, R10 dither gating
        two_stage_i = 1'b1; dither_i = 1'b0; frac_i = W'(37);
        do_reset();
        for (int i = 0; i < 300; i++) begin
            if (i % 5 == 0) two_stage_i = ~two_stage_i;
            if (i % 7 == 0) dither_i = ~dither_i;
            if (i % 11 == 0) frac_i = W'((i * 13 + 5) % N);
            advance("R9 mixed mode step");
            if (i % 4 == 3) begin
                int held;
                held = int'(offset_o);
                for (int w = 0; w < 3; w++) begin
                    @(negedge clk);
                    check("R6 output held while idle", int'(offset_o), held);
                end
            end
        end
        // R10: dither off over many steps, toggle must be left as it was
        dither_i = 1'b0; two_stage_i = 1'b1;
        for (int i = 0; i < 20; i++) advance("R10 dither off step");
        dither_i = 1'b1;
        for (int i = 0; i < 20; i++) advance("R10 toggle resumes");

        // R1 reset mid-run
        do_reset();
        check("R1 reset clears mid-run", int'(offset_o), 0);
        frac_i = W'(N - 1); two_stage_i = 1'b0; dither_i = 1'b0;
        for (int i = 0; i < 8; i++) advance("R1 restart from zero state");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule